// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a bank of asynchronous input pins plus one separate non-maskable pin. It raises a sticky flag for a channel whenever that channel's programmed condition is seen. The condition is one of rising edge, falling edge, either edge, high level or low level. Every pin is first brought into the clock domain by a two-flop synchronizer. A per-channel three-sample majority filter can then be switched in to reject single-cycle glitches before detection. A channel whose event output is enabled also produces a one-cycle pulse on each cycle in which its condition is detected.

Software drives the block through a small register port: a write strobe, a read strobe, a word address, write data and registered read data. The port holds a global enable and a self-clearing software reset. It also holds the per-channel sense codes, filter selects and event enables, the non-maskable channel's own setup, and two flag registers that are cleared by writing ones. A write-protect input freezes every configuration register but leaves both flag registers clearable. A debug-halt input is accepted and has no effect on detection.

Top module: `ext_irq_ctrl`

## Requirements
- R1: A 3-bit sense code selects the detected condition: 1 rising edge, 2 falling edge, 3 either edge, 4 high level, 5 low level. Channel i's code sits in bits [3i+2:3i] of the sense register at address 3.
- R2: A channel whose sense code is 0, 6 or 7 never sets its flag, whatever its pin does.
- R3: Bit i of the filter register (address 2) routes channel i through a majority vote of its last three synchronized samples. A one-cycle pin pulse then sets no flag. With the filter off, the same pulse is caught by an edge code.
- R4: Bit 0 of the control register (address 0) is the global enable. While it is 0, no regular or non-maskable flag is set and no event pulse is produced.
- R5: The flag register (address 4) reads the channel flags. Writing 1 to bit i clears flag i. A set condition in the same cycle as the clear wins. A level code sets its flag again on every cycle the level holds.
- R6: Writing a 1 to bit 1 of the control register returns every register to its reset value, including the flags and the enable, and leaves the block disabled. Bit 1 always reads 0.
- R7: While wprot_i is high, writes to the control, event-enable, filter, sense and non-maskable setup registers are ignored. Clearing writes to both flag registers still take effect.
- R8: With bit i of the event-enable register (address 1) set, evt_o[i] pulses high for one cycle each time channel i's condition is detected. An edge therefore gives exactly one pulse.
- R9: The non-maskable channel takes its sense code from bits [2:0] of address 5 and its filter select from bit 3 of the same register. Its flag appears on nmi_o and as bit 0 of address 6, where writing 1 clears it. It does not interact with the regular channels.
- R10: dbg_halt_i has no effect on detection, flags or events.
- R11: A read strobe in one cycle presents the addressed register on rdata_o after the next clock edge. Enable reads back in bit 0 of address 0.
- R12: A pin change made between clock edges shows up on the flag after the 4th following rising edge with the filter off, and after the 5th with the filter on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register port and detection |
| rst | input | 1 | Synchronous active-high reset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | AW | Register word address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Registered read data |
| wprot_i | input | 1 | Write protect for configuration registers |
| dbg_halt_i | input | 1 | Debug halt indication, no effect |
| pins_i | input | NCH | Asynchronous interrupt pins |
| nmi_pin_i | input | 1 | Asynchronous non-maskable pin |
| irq_o | output | NCH | Per-channel sticky flags |
| evt_o | output | NCH | Per-channel one-cycle event pulses |
| nmi_o | output | 1 | Non-maskable flag |

## Verification
The bench checks the exact flag latency with and without the filter. A design with one synchronizer stage too few or too many flags a cycle early or late. It sends a one-cycle pulse to a filtered and an unfiltered channel together, so a filter that votes on too few samples flags the wrong one. It also clears a level-sensed flag while the level still holds, where a clear that wins the tie would drop the flag. Randomized sense codes, pin transitions and filter choices, including the unused codes 6 and 7, are compared against a bench model of each condition. Directed steps confirm that protection blocks the software reset and the sense writes but not the flag clears, and that the event counter sees exactly one pulse per edge.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam logic [2:0] SN_RISE = 3'd1;
  localparam logic [2:0] SN_FALL = 3'd2;
  localparam logic [2:0] SN_BOTH = 3'd3;
  localparam logic [2:0] SN_HIGH = 3'd4;
  localparam logic [2:0] SN_LOW  = 3'd5;

  localparam int A_CTRL    = 0;
  localparam int A_EVEN    = 1;
  localparam int A_FILT    = 2;
  localparam int A_SENSE   = 3;
  localparam int A_FLAG    = 4;
  localparam int A_NMICFG  = 5;
  localparam int A_NMIFLAG = 6;
endpackage

// File: rtl/eic_pin_front.sv
module eic_pin_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic filt_en_i,
  output logic cur_o,
  output logic prev_o
);
  localparam int TAPS = 3;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [TAPS-1:0]        hist_q;
  logic                   prev_q;
  logic                   vote;

  assign vote  = (hist_q[0] & hist_q[1]) | (hist_q[0] & hist_q[2]) | (hist_q[1] & hist_q[2]);
  assign cur_o = filt_en_i ? vote : hist_q[0];
  assign prev_o = prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      hist_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      hist_q <= {hist_q[TAPS-2:0], sync_q[SYNC_STAGES-1]};
      prev_q <= cur_o;
    end
  end
endmodule

// File: rtl/eic_sense_match.sv
module eic_sense_match
  import eic_pkg::*;
(
  input  logic [2:0] code_i,
  input  logic       cur_i,
  input  logic       prev_i,
  output logic       hit_o
);
  always_comb begin
    case (code_i)
      SN_RISE: hit_o = cur_i & ~prev_i;
      SN_FALL: hit_o = ~cur_i & prev_i;
      SN_BOTH: hit_o = cur_i ^ prev_i;
      SN_HIGH: hit_o = cur_i;
      SN_LOW:  hit_o = ~cur_i;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eic_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 3,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_i,
  input  logic           rd_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  input  logic           wprot_i,
  input  logic           dbg_halt_i,
  input  logic [NCH-1:0] pins_i,
  input  logic           nmi_pin_i,
  output logic [NCH-1:0] irq_o,
  output logic [NCH-1:0] evt_o,
  output logic           nmi_o
);
  localparam int SW = 3 * NCH;

  logic           en_q;
  logic [NCH-1:0] even_q, filt_q, flag_q, evt_q;
  logic [SW-1:0]  sense_q;
  logic [3:0]     nmi_cfg_q;
  logic           nmi_flag_q;
  logic [DW-1:0]  rdata_q;

  logic [NCH-1:0] cur, prev, match, hit, clr;
  logic           nmi_cur, nmi_prev, nmi_match, nmi_hit, nmi_clr;
  logic           wr_ok, sw_rst;
  logic           unused_ins;

  assign unused_ins = ^{dbg_halt_i, wdata_i};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    eic_pin_front u_front (
      .clk(clk), .rst(rst), .pin_i(pins_i[i]), .filt_en_i(filt_q[i]),
      .cur_o(cur[i]), .prev_o(prev[i])
    );
    eic_sense_match u_match (
      .code_i(sense_q[3*i +: 3]), .cur_i(cur[i]), .prev_i(prev[i]), .hit_o(match[i])
    );
  end

  eic_pin_front u_nmi_front (
    .clk(clk), .rst(rst), .pin_i(nmi_pin_i), .filt_en_i(nmi_cfg_q[3]),
    .cur_o(nmi_cur), .prev_o(nmi_prev)
  );
  eic_sense_match u_nmi_match (
    .code_i(nmi_cfg_q[2:0]), .cur_i(nmi_cur), .prev_i(nmi_prev), .hit_o(nmi_match)
  );

  assign hit     = en_q ? match : '0;
  assign nmi_hit = en_q & nmi_match;
  assign wr_ok   = wr_i & ~wprot_i;
  assign sw_rst  = wr_ok && (addr_i == AW'(A_CTRL)) && wdata_i[1];
  assign clr     = (wr_i && addr_i == AW'(A_FLAG)) ? wdata_i[NCH-1:0] : '0;
  assign nmi_clr = wr_i && (addr_i == AW'(A_NMIFLAG)) && wdata_i[0];

  always_ff @(posedge clk) begin
    if (rst || sw_rst) begin
      en_q       <= 1'b0;
      even_q     <= '0;
      filt_q     <= '0;
      sense_q    <= '0;
      nmi_cfg_q  <= '0;
      flag_q     <= '0;
      nmi_flag_q <= 1'b0;
      evt_q      <= '0;
    end else begin
      if (wr_ok) begin
        case (addr_i)
          AW'(A_CTRL):   en_q      <= wdata_i[0];
          AW'(A_EVEN):   even_q    <= wdata_i[NCH-1:0];
          AW'(A_FILT):   filt_q    <= wdata_i[NCH-1:0];
          AW'(A_SENSE):  sense_q   <= wdata_i[SW-1:0];
          AW'(A_NMICFG): nmi_cfg_q <= wdata_i[3:0];
          default: ;
        endcase
      end
      flag_q     <= (flag_q & ~clr) | hit;
      nmi_flag_q <= (nmi_flag_q & ~nmi_clr) | nmi_hit;
      evt_q      <= hit & even_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      case (addr_i)
        AW'(A_CTRL):    rdata_q <= DW'(en_q);
        AW'(A_EVEN):    rdata_q <= DW'(even_q);
        AW'(A_FILT):    rdata_q <= DW'(filt_q);
        AW'(A_SENSE):   rdata_q <= DW'(sense_q);
        AW'(A_FLAG):    rdata_q <= DW'(flag_q);
        AW'(A_NMICFG):  rdata_q <= DW'(nmi_cfg_q);
        AW'(A_NMIFLAG): rdata_q <= DW'(nmi_flag_q);
        default:        rdata_q <= '0;
      endcase
    end else begin
      rdata_q <= '0;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = flag_q;
  assign evt_o   = evt_q;
  assign nmi_o   = nmi_flag_q;
endmodule

// File: rtl/eic_chk.sv
module eic_chk #(
  parameter int NCH = 8,
  parameter int AW  = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_i,
  input logic           wprot_i,
  input logic [AW-1:0]  addr_i,
  input logic           swrst_bit,
  input logic           en_q,
  input logic [3*NCH-1:0] sense_q,
  input logic [NCH-1:0] hit,
  input logic [NCH-1:0] irq_o,
  input logic [NCH-1:0] evt_o,
  input logic           nmi_o
);
  logic sw;
  assign sw = wr_i && !wprot_i && (addr_i == AW'(0)) && swrst_bit;

  for (genvar i = 0; i < NCH; i++) begin : g_a
    a_r2_zero_sense_quiet: assert property (@(posedge clk) disable iff (rst)
      (sense_q[3*i +: 3] == 3'd0 && !irq_o[i]) |=> !irq_o[i]);
    a_r4_disabled_no_set: assert property (@(posedge clk) disable iff (rst)
      (!en_q && !irq_o[i]) |=> !irq_o[i]);
    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
      (hit[i] && !sw) |=> irq_o[i]);
    a_r8_event_has_flag: assert property (@(posedge clk) disable iff (rst)
      evt_o[i] |-> irq_o[i]);
  end

  a_r7_sense_protected: assert property (@(posedge clk) disable iff (rst)
    (wprot_i && wr_i && addr_i == AW'(3)) |=> $stable(sense_q));
  a_r6_swrst_clears: assert property (@(posedge clk) disable iff (rst)
    sw |=> (!en_q && irq_o == '0 && !nmi_o));
endmodule

bind ext_irq_ctrl eic_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .wr_i(wr_i), .wprot_i(wprot_i), .addr_i(addr_i),
  .swrst_bit(wdata_i[1]), .en_q(en_q), .sense_q(sense_q), .hit(hit),
  .irq_o(irq_o), .evt_o(evt_o), .nmi_o(nmi_o)
);

// File: tb/tb_ext_irq_ctrl.sv
module tb_ext_irq_ctrl;
  localparam int NCH = 8;
  localparam int AW = 3;
  localparam int DW = 32;

  logic clk = 0, rst = 1;
  logic wr_i = 0, rd_i = 0, wprot_i = 0, dbg_halt_i = 0, nmi_pin_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic [NCH-1:0] pins_i = '0;
  logic [NCH-1:0] irq_o, evt_o;
  logic nmi_o;

  int checks = 0, fails = 0;
  int ev_ch = 0, ev_cnt = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  ext_irq_ctrl #(.NCH(NCH), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .wprot_i(wprot_i), .dbg_halt_i(dbg_halt_i), .pins_i(pins_i),
    .nmi_pin_i(nmi_pin_i), .irq_o(irq_o), .evt_o(evt_o), .nmi_o(nmi_o)
  );

  always @(posedge clk) if (evt_o[ev_ch]) ev_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_i = 1; addr_i = AW'(a); wdata_i = d;
    @(negedge clk); wr_i = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); rd_i = 1; addr_i = AW'(a);
    @(negedge clk); rd_i = 0; d = rdata_o;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic exp_flag(input logic [2:0] c, input logic o, input logic n);
    case (c)
      3'd1: return !o && n;
      3'd2: return o && !n;
      3'd3: return o ^ n;
      3'd4: return o || n;
      3'd5: return !o || !n;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    idle(2);
    chk("R6 reset irq", 32'(irq_o), 0);
    chk("R6 reset evt/nmi", {evt_o, nmi_o}, 0);
    rd(0, rv); chk("R11 reset ctrl", rv, 0);

    wr(0, 1);
    rd(0, rv); chk("R11 enable readback", rv, 1);

    // R12 latency, unfiltered channel 0 rise
    wr(3, 32'h0000_0009); // ch0 rise, ch1 rise
    wr(2, 32'h2);          // ch1 filtered
    idle(4);
    pins_i[0] = 1;
    idle(3); chk("R12 unfiltered not before 4", 32'(irq_o[0]), 0);
    idle(1); chk("R12 unfiltered at 4", 32'(irq_o[0]), 1);
    pins_i[1] = 1;
    idle(4); chk("R12 filtered not before 5", 32'(irq_o[1]), 0);
    idle(1); chk("R12 filtered at 5", 32'(irq_o[1]), 1);

    // R3 glitch reject
    pins_i[1:0] = 2'b00; idle(8);
    wr(4, 32'hFF);
    pins_i[1:0] = 2'b11; idle(1); pins_i[1:0] = 2'b00; idle(8);
    chk("R3 unfiltered catches pulse", 32'(irq_o[0]), 1);
    chk("R3 filtered rejects pulse", 32'(irq_o[1]), 0);

    // R5 level high with clear while level holds
    wr(3, 32'h0000_0100); // ch2 high
    pins_i[2] = 1; idle(6);
    wr(4, 32'hFF);
    rd(4, rv); chk("R5 set wins over clear", rv, 32'h4);
    pins_i[2] = 0; idle(6);
    wr(4, 32'h4);
    chk("R5 clear after level gone", 32'(irq_o[2]), 0);

    // R4 disabled
    wr(3, 32'h1); wr(0, 0); wr(4, 32'hFF);
    pins_i[0] = 1; idle(8);
    chk("R4 no flag while disabled", 32'(irq_o), 0);
    pins_i[0] = 0; idle(8);
    wr(0, 1);

    // R7 write protect
    wr(3, 32'h0000_0100); pins_i[2] = 1; idle(6);
    wprot_i = 1;
    wr(3, 32'h0);
    rd(3, rv); chk("R7 sense write ignored", rv, 32'h100);
    wr(0, 32'h2);
    rd(0, rv); chk("R7 swrst ignored", rv, 1);
    pins_i[2] = 0; idle(6);
    wr(4, 32'h4);
    chk("R7 flag clear still works", 32'(irq_o[2]), 0);
    wprot_i = 0;

    // R9 NMI falling
    wr(5, 32'h2);
    nmi_pin_i = 1; idle(8);
    chk("R9 no nmi on rise", 32'(nmi_o), 0);
    nmi_pin_i = 0; idle(8);
    chk("R9 nmi on fall", 32'(nmi_o), 1);
    chk("R9 regular flags untouched", 32'(irq_o), 0);
    wprot_i = 1; wr(6, 1); wprot_i = 0;
    rd(6, rv); chk("R9 nmi flag cleared under protect", rv, 0);

    // R6 software reset
    pins_i[2] = 1; idle(6);
    wr(0, 32'h3);
    chk("R6 flags cleared", {23'd0, nmi_o, irq_o}, 0);
    rd(0, rv); chk("R6 disabled after swrst", rv, 0);
    rd(3, rv); chk("R6 sense cleared", rv, 0);
    pins_i[2] = 0; idle(6);
    wr(0, 1);

    // R1 R2 R8 R10 randomized
    for (int it = 0; it < 60; it++) begin
      int ch;
      logic [2:0] code;
      logic f, o, n, e;
      ch = int'($urandom % NCH);
      code = 3'($urandom % 8);
      f = 1'($urandom % 2);
      o = 1'($urandom % 2);
      n = 1'($urandom % 2);
      dbg_halt_i = 1'($urandom % 2);
      wr(3, 32'(code) << (3 * ch));
      wr(2, 32'(f) << ch);
      wr(1, 32'(1) << ch);
      ev_ch = ch;
      pins_i[ch] = o; idle(8);
      wr(4, 32'hFF);
      ev_cnt = 0;
      pins_i[ch] = n; idle(8);
      e = exp_flag(code, o, n);
      chk((code == 0 || code > 5) ? "R2 idle code" : "R1/R10 sensed", 32'(irq_o[ch]), 32'(e));
      if (code >= 1 && code <= 3) chk("R8 event count", ev_cnt, 32'(e));
    end
    dbg_halt_i = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule